// File: doc/BRIEF.md
# Tick-Driven Transmit Slot Sequencer

This block paces the outbound side of one network interface under a fixed time-division schedule. Software loads a small schedule table while the block is stopped. Each row of the table names either a channel or an empty gap, gives a length counted in coarse global ticks, and may carry a flag that closes the cycle. Once enabled, the block moves through the table and advances only when a tick pulse arrives. After the flagged row it starts again from row 0, so one pass through the table is one hyperperiod.

Each channel owns a short ring of static buffer descriptors. A descriptor holds a source address, a destination address and a byte count. When a channel row begins, the block takes the channel's current descriptor and fires a one-cycle request to the DMA engine that carries that descriptor. It then moves the channel's ring pointer on by one, so exactly one buffer goes out per activation. Over successive activations the channel cycles through its buffers.

The block also reports where slots start and end, naming the channel in each case. If a channel row ends on the same tick that another channel row begins, both reports appear in the same cycle. If the DMA engine still reports busy at the moment a new transfer is launched, the block sets a sticky overrun flag. The transfer is issued anyway.

Top module: `tdm_slot_seq`

## Requirements
- R1: After reset, the start request, both slot reports and the overrun flag are low.
- R2: The walk advances only in a cycle where `tick` is high. No request and no slot report appears one cycle after a cycle in which `tick` was low.
- R3: The first tick after `en` rises enters row 0. A row of length D (a length of 0 counts as 1) is left on the D-th tick after the tick that entered it. The row after row i is row i+1, except that row 0 follows a row with the wrap flag set and also follows the last row of the table.
- R4: `dma_start` is a one-cycle pulse that goes high exactly in the cycle after a tick that enters a non-empty row. It stays low on ticks that stay within a row and on ticks that enter an empty row.
- R5: Each activation of channel c carries the descriptor at c's current ring position on `dma_src`, `dma_dst`, `dma_size` and `dma_ch`, and then moves that position on by one. After a descriptor whose wrap flag is set, or after the last ring position, the position returns to 0.
- R6: In the cycle after a tick that leaves a non-empty row, `slot_end` is high and `slot_end_ch` names that row's channel. In the cycle after a tick that enters a non-empty row, `slot_begin` is high and `slot_begin_ch` names the new channel. Both appear in the same cycle when one tick does both.
- R7: Writes to the schedule table and to the descriptor store take effect only while `en` is low. While `en` is high they are ignored.
- R8: While `en` is low, the block issues nothing, returns to row 0, resets every ring position to 0 and clears the overrun flag.
- R9: If `dma_busy` is high on a tick that launches a transfer, `overrun` rises in the next cycle and stays high while `en` stays high. The request is still issued.
- R10: `dma_busy` has no effect on `overrun` on ticks that launch no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low stops the walk and permits loading |
| tick | input | 1 | Global tick pulse, one cycle wide |
| dma_busy | input | 1 | DMA engine still busy with the previous transfer |
| tbl_we | input | 1 | Schedule row write strobe |
| tbl_addr | input | TAW | Row being written |
| tbl_idle | input | 1 | Row is an empty gap |
| tbl_last | input | 1 | Row closes the hyperperiod |
| tbl_ch | input | CW | Channel that owns the row |
| tbl_dur | input | DURW | Row length in ticks |
| buf_we | input | 1 | Descriptor write strobe |
| buf_ch | input | CW | Channel of the descriptor |
| buf_idx | input | BIW | Ring position of the descriptor |
| buf_last | input | 1 | Ring wraps after this descriptor |
| buf_src | input | ADDRW | Source address |
| buf_dst | input | ADDRW | Destination address |
| buf_size | input | SZW | Transfer size in bytes |
| dma_start | output | 1 | One-cycle transfer request |
| dma_ch | output | CW | Channel of the request |
| dma_src | output | ADDRW | Source address of the request |
| dma_dst | output | ADDRW | Destination address of the request |
| dma_size | output | SZW | Byte count of the request |
| slot_end | output | 1 | A channel slot has ended |
| slot_end_ch | output | CW | Channel whose slot ended |
| slot_begin | output | 1 | A channel slot has begun |
| slot_begin_ch | output | CW | Channel whose slot began |
| overrun | output | 1 | Sticky flag: a launch happened while the DMA was busy |

## Verification
Every result of the block is registered once after the clock edge that samples `tick`. The request, the descriptor fields, both slot reports and the overrun flag for a tick are therefore due in the cycle right after that edge, and nothing is due in any other cycle. The driver raises `tick` on a falling edge and queues the result it expects for that tick. The monitor notes each rising edge at which `tick` was high and compares on the next falling edge, when the registered outputs are stable. On every other falling edge it checks that the request and both reports are low, so a late, early or extra pulse shows up as a mismatch. The overrun level is compared after every tick, which also covers its stickiness and the ticks where `dma_busy` must have no effect.

// File: rtl/tdm_seq_pkg.sv
package tdm_seq_pkg;

    // Walk state: waiting for the first tick after enable, or stepping rows.
    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/tdm_sched_table.sv
// Schedule row storage: one write port usable only while stopped,
// one combinational read port driven by the walker.
module tdm_sched_table #(
    parameter int DEPTH = 16,
    parameter int NCH   = 4,
    parameter int DURW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic                     w_idle,
    input  logic                     w_last,
    input  logic [$clog2(NCH)-1:0]   w_ch,
    input  logic [DURW-1:0]          w_dur,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic                     r_idle,
    output logic                     r_last,
    output logic [$clog2(NCH)-1:0]   r_ch,
    output logic [DURW-1:0]          r_dur
);
    localparam int TAW = $clog2(DEPTH);
    localparam int CW  = $clog2(NCH);

    typedef struct packed {
        logic            idle;
        logic            last;
        logic [CW-1:0]   ch;
        logic [DURW-1:0] dur;
    } row_t;

    localparam row_t ROW_RST = '{idle: 1'b1, last: 1'b1, ch: '0, dur: DURW'(1)};

    row_t rows_q [DEPTH];
    row_t rows_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            rows_d[i] = rows_q[i];
        end
        if (we && !en) begin
            rows_d[waddr] = '{idle: w_idle, last: w_last, ch: w_ch, dur: w_dur};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                rows_q[i] <= ROW_RST;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                rows_q[i] <= rows_d[i];
            end
        end
    end

    assign r_idle = rows_q[raddr].idle;
    assign r_last = rows_q[raddr].last;
    assign r_ch   = rows_q[raddr].ch;
    assign r_dur  = rows_q[raddr].dur;

    // R7: the table holds still while the walk runs.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hold
        p_rows_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
            en |=> $stable(rows_q[g]))
            else $error("row %0d changed while running", g);
    end

    logic unused_taw;
    assign unused_taw = ^TAW;

endmodule

// File: rtl/tdm_buf_ring.sv
// Per-channel static buffer descriptors with a rotating read position.
module tdm_buf_ring #(
    parameter int NCH   = 4,
    parameter int NBUF  = 4,
    parameter int ADDRW = 32,
    parameter int SZW   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    we,
    input  logic [$clog2(NCH)-1:0]  w_ch,
    input  logic [$clog2(NBUF)-1:0] w_idx,
    input  logic                    w_last,
    input  logic [ADDRW-1:0]        w_src,
    input  logic [ADDRW-1:0]        w_dst,
    input  logic [SZW-1:0]          w_size,
    input  logic [$clog2(NCH)-1:0]  sel_ch,
    input  logic                    adv,
    output logic [ADDRW-1:0]        r_src,
    output logic [ADDRW-1:0]        r_dst,
    output logic [SZW-1:0]          r_size
);
    localparam int CW  = $clog2(NCH);
    localparam int BIW = $clog2(NBUF);

    typedef struct packed {
        logic             last;
        logic [ADDRW-1:0] src;
        logic [ADDRW-1:0] dst;
        logic [SZW-1:0]   size;
    } desc_t;

    desc_t          desc_q [NCH][NBUF];
    desc_t          desc_d [NCH][NBUF];
    logic [BIW-1:0] pos_q  [NCH];
    logic [BIW-1:0] pos_d  [NCH];

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < NBUF; b++) begin
                desc_d[c][b] = desc_q[c][b];
            end
            pos_d[c] = pos_q[c];
        end
        if (we && !en) begin
            desc_d[w_ch][w_idx] = '{last: w_last, src: w_src, dst: w_dst, size: w_size};
        end
        if (!en) begin
            for (int c = 0; c < NCH; c++) begin
                pos_d[c] = '0;
            end
        end else if (adv) begin
            if (desc_q[sel_ch][pos_q[sel_ch]].last ||
                pos_q[sel_ch] == BIW'(NBUF - 1)) begin
                pos_d[sel_ch] = '0;
            end else begin
                pos_d[sel_ch] = pos_q[sel_ch] + BIW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                for (int b = 0; b < NBUF; b++) begin
                    desc_q[c][b] <= '0;
                end
                pos_q[c] <= '0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                for (int b = 0; b < NBUF; b++) begin
                    desc_q[c][b] <= desc_d[c][b];
                end
                pos_q[c] <= pos_d[c];
            end
        end
    end

    assign r_src  = desc_q[sel_ch][pos_q[sel_ch]].src;
    assign r_dst  = desc_q[sel_ch][pos_q[sel_ch]].dst;
    assign r_size = desc_q[sel_ch][pos_q[sel_ch]].size;

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R5: an activation steps the ring by one or wraps it to 0.
        p_ring_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (en && adv && sel_ch == CW'(g)) |=>
                (pos_q[g] == 0 || pos_q[g] == $past(pos_q[g]) + BIW'(1)))
            else $error("ring %0d stepped wrongly", g);
        // R5: rings of channels that are not activated hold still.
        p_ring_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (en && !(adv && sel_ch == CW'(g))) |=> $stable(pos_q[g]))
            else $error("ring %0d moved without activation", g);
        // R8: stopping returns the ring to position 0.
        p_ring_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> pos_q[g] == 0)
            else $error("ring %0d not cleared", g);
    end

endmodule

// File: rtl/tdm_walker.sv
// Tick-driven row walker: counts row lengths, launches transfers and
// raises slot reports; all outputs are registered.
module tdm_walker
    import tdm_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NCH   = 4,
    parameter int ADDRW = 32,
    parameter int SZW   = 16,
    parameter int DURW  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     tick,
    input  logic                     dma_busy,
    output logic [$clog2(DEPTH)-1:0] raddr,
    input  logic                     r_idle,
    input  logic                     r_last,
    input  logic [$clog2(NCH)-1:0]   r_ch,
    input  logic [DURW-1:0]          r_dur,
    input  logic [ADDRW-1:0]         d_src,
    input  logic [ADDRW-1:0]         d_dst,
    input  logic [SZW-1:0]           d_size,
    output logic                     adv,
    output logic                     dma_start,
    output logic [$clog2(NCH)-1:0]   dma_ch,
    output logic [ADDRW-1:0]         dma_src,
    output logic [ADDRW-1:0]         dma_dst,
    output logic [SZW-1:0]           dma_size,
    output logic                     slot_end,
    output logic [$clog2(NCH)-1:0]   slot_end_ch,
    output logic                     slot_begin,
    output logic [$clog2(NCH)-1:0]   slot_begin_ch,
    output logic                     overrun
);
    localparam int TAW = $clog2(DEPTH);
    localparam int CW  = $clog2(NCH);

    typedef struct packed {
        seq_state_e       st;
        logic [TAW-1:0]   ptr;
        logic [DURW-1:0]  rem;
        logic             cur_idle;
        logic             cur_last;
        logic [CW-1:0]    cur_ch;
        logic             start;
        logic [CW-1:0]    dch;
        logic [ADDRW-1:0] src;
        logic [ADDRW-1:0] dst;
        logic [SZW-1:0]   size;
        logic             s_end;
        logic [CW-1:0]    end_ch;
        logic             s_beg;
        logic [CW-1:0]    beg_ch;
        logic             ovr;
    } walk_t;

    walk_t walk_q;
    walk_t walk_d;
    logic  enter_row;
    logic  row_done;
    logic [TAW-1:0] ptr_next;

    // Row that would be entered on the coming tick.
    assign ptr_next = (walk_q.cur_last || walk_q.ptr == TAW'(DEPTH - 1))
                    ? '0 : walk_q.ptr + TAW'(1);
    assign raddr    = (walk_q.st == ST_WAIT) ? '0 : ptr_next;
    assign row_done = (walk_q.rem <= DURW'(1));
    assign enter_row = en && tick && (walk_q.st == ST_WAIT || row_done);
    assign adv      = enter_row && !r_idle;

    always_comb begin
        walk_d       = walk_q;
        walk_d.start = 1'b0;
        walk_d.s_end = 1'b0;
        walk_d.s_beg = 1'b0;
        if (!en) begin
            walk_d = '0;
        end else if (tick) begin
            if (walk_q.st == ST_RUN && row_done && !walk_q.cur_idle) begin
                walk_d.s_end  = 1'b1;
                walk_d.end_ch = walk_q.cur_ch;
            end
            if (!enter_row) begin
                walk_d.rem = walk_q.rem - DURW'(1);
            end else begin
                walk_d.st       = ST_RUN;
                walk_d.ptr      = raddr;
                walk_d.rem      = r_dur;
                walk_d.cur_idle = r_idle;
                walk_d.cur_last = r_last;
                walk_d.cur_ch   = r_ch;
                if (!r_idle) begin
                    walk_d.s_beg  = 1'b1;
                    walk_d.beg_ch = r_ch;
                    walk_d.start  = 1'b1;
                    walk_d.dch    = r_ch;
                    walk_d.src    = d_src;
                    walk_d.dst    = d_dst;
                    walk_d.size   = d_size;
                    if (dma_busy) begin
                        walk_d.ovr = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign dma_start     = walk_q.start;
    assign dma_ch        = walk_q.dch;
    assign dma_src       = walk_q.src;
    assign dma_dst       = walk_q.dst;
    assign dma_size      = walk_q.size;
    assign slot_end      = walk_q.s_end;
    assign slot_end_ch   = walk_q.end_ch;
    assign slot_begin    = walk_q.s_beg;
    assign slot_begin_ch = walk_q.beg_ch;
    assign overrun       = walk_q.ovr;

    // R2: nothing is reported after a cycle without a tick.
    p_quiet_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!dma_start && !slot_begin && !slot_end))
        else $error("output pulse without a tick");

    // R9: overrun stays set while running.
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && overrun) |=> overrun)
        else $error("overrun dropped while running");

    // R8: a stopped walker issues nothing and waits for row 0.
    p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!dma_start && !overrun && walk_q.st == ST_WAIT))
        else $error("activity while stopped");

    // R4: a start request never repeats within one row.
    p_start_new_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && walk_q.st == ST_RUN && !row_done) |=> !dma_start)
        else $error("start issued inside a continuing row");

endmodule

// File: rtl/tdm_slot_seq.sv
// Top: table-driven time-division transmit slot sequencer.
module tdm_slot_seq #(
    parameter int DEPTH = 16,
    parameter int NCH   = 4,
    parameter int NBUF  = 4,
    parameter int ADDRW = 32,
    parameter int SZW   = 16,
    parameter int DURW  = 8,
    localparam int TAW  = $clog2(DEPTH),
    localparam int CW   = $clog2(NCH),
    localparam int BIW  = $clog2(NBUF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             dma_busy,
    input  logic             tbl_we,
    input  logic [TAW-1:0]   tbl_addr,
    input  logic             tbl_idle,
    input  logic             tbl_last,
    input  logic [CW-1:0]    tbl_ch,
    input  logic [DURW-1:0]  tbl_dur,
    input  logic             buf_we,
    input  logic [CW-1:0]    buf_ch,
    input  logic [BIW-1:0]   buf_idx,
    input  logic             buf_last,
    input  logic [ADDRW-1:0] buf_src,
    input  logic [ADDRW-1:0] buf_dst,
    input  logic [SZW-1:0]   buf_size,
    output logic             dma_start,
    output logic [CW-1:0]    dma_ch,
    output logic [ADDRW-1:0] dma_src,
    output logic [ADDRW-1:0] dma_dst,
    output logic [SZW-1:0]   dma_size,
    output logic             slot_end,
    output logic [CW-1:0]    slot_end_ch,
    output logic             slot_begin,
    output logic [CW-1:0]    slot_begin_ch,
    output logic             overrun
);
    logic [TAW-1:0]   rd_addr;
    logic             rd_idle;
    logic             rd_last;
    logic [CW-1:0]    rd_ch;
    logic [DURW-1:0]  rd_dur;
    logic [ADDRW-1:0] sel_src;
    logic [ADDRW-1:0] sel_dst;
    logic [SZW-1:0]   sel_size;
    logic             ring_adv;

    tdm_sched_table #(
        .DEPTH (DEPTH),
        .NCH   (NCH),
        .DURW  (DURW)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .we     (tbl_we),
        .waddr  (tbl_addr),
        .w_idle (tbl_idle),
        .w_last (tbl_last),
        .w_ch   (tbl_ch),
        .w_dur  (tbl_dur),
        .raddr  (rd_addr),
        .r_idle (rd_idle),
        .r_last (rd_last),
        .r_ch   (rd_ch),
        .r_dur  (rd_dur)
    );

    tdm_buf_ring #(
        .NCH   (NCH),
        .NBUF  (NBUF),
        .ADDRW (ADDRW),
        .SZW   (SZW)
    ) u_ring (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .we     (buf_we),
        .w_ch   (buf_ch),
        .w_idx  (buf_idx),
        .w_last (buf_last),
        .w_src  (buf_src),
        .w_dst  (buf_dst),
        .w_size (buf_size),
        .sel_ch (rd_ch),
        .adv    (ring_adv),
        .r_src  (sel_src),
        .r_dst  (sel_dst),
        .r_size (sel_size)
    );

    tdm_walker #(
        .DEPTH (DEPTH),
        .NCH   (NCH),
        .ADDRW (ADDRW),
        .SZW   (SZW),
        .DURW  (DURW)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .tick          (tick),
        .dma_busy      (dma_busy),
        .raddr         (rd_addr),
        .r_idle        (rd_idle),
        .r_last        (rd_last),
        .r_ch          (rd_ch),
        .r_dur         (rd_dur),
        .d_src         (sel_src),
        .d_dst         (sel_dst),
        .d_size        (sel_size),
        .adv           (ring_adv),
        .dma_start     (dma_start),
        .dma_ch        (dma_ch),
        .dma_src       (dma_src),
        .dma_dst       (dma_dst),
        .dma_size      (dma_size),
        .slot_end      (slot_end),
        .slot_end_ch   (slot_end_ch),
        .slot_begin    (slot_begin),
        .slot_begin_ch (slot_begin_ch),
        .overrun       (overrun)
    );

endmodule

// File: tb/tdm_slot_seq_tb_top.sv
module tdm_slot_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        tick = 1'b0;
    logic        dma_busy = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic        tbl_idle = 1'b0;
    logic        tbl_last = 1'b0;
    logic [1:0]  tbl_ch = '0;
    logic [7:0]  tbl_dur = '0;
    logic        buf_we = 1'b0;
    logic [1:0]  buf_ch = '0;
    logic [1:0]  buf_idx = '0;
    logic        buf_last = 1'b0;
    logic [31:0] buf_src = '0;
    logic [31:0] buf_dst = '0;
    logic [15:0] buf_size = '0;
    logic        dma_start;
    logic [1:0]  dma_ch;
    logic [31:0] dma_src;
    logic [31:0] dma_dst;
    logic [15:0] dma_size;
    logic        slot_end;
    logic [1:0]  slot_end_ch;
    logic        slot_begin;
    logic [1:0]  slot_begin_ch;
    logic        overrun;

    always #5 clk = ~clk;

    tdm_slot_seq dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .dma_busy(dma_busy),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_idle(tbl_idle),
        .tbl_last(tbl_last), .tbl_ch(tbl_ch), .tbl_dur(tbl_dur),
        .buf_we(buf_we), .buf_ch(buf_ch), .buf_idx(buf_idx), .buf_last(buf_last),
        .buf_src(buf_src), .buf_dst(buf_dst), .buf_size(buf_size),
        .dma_start(dma_start), .dma_ch(dma_ch), .dma_src(dma_src),
        .dma_dst(dma_dst), .dma_size(dma_size), .slot_end(slot_end),
        .slot_end_ch(slot_end_ch), .slot_begin(slot_begin),
        .slot_begin_ch(slot_begin_ch), .overrun(overrun)
    );

    typedef struct {
        logic        start;
        logic [1:0]  ch;
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] size;
        logic        s_end;
        logic [1:0]  end_ch;
        logic        s_beg;
        logic [1:0]  beg_ch;
        logic        ovr;
    } exp_t;

    exp_t  exp_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R3";
    logic  pend = 1'b0;

    // Reference model state, written from the requirements.
    logic       m_tidle [16];
    logic       m_tlast [16];
    logic [1:0] m_tch   [16];
    logic [7:0] m_tdur  [16];
    logic       m_blast [4][4];
    int         m_bpos  [4];
    bit         m_run;
    int         m_ptr;
    int         m_rem;
    bit         m_ovr;

    function automatic logic [31:0] src_of(int c, int b);
        return 32'h1000_0000 + 32'(c * 256 + b * 16);
    endfunction
    function automatic logic [31:0] dst_of(int c, int b);
        return 32'h2000_0000 + 32'(c * 512 + b * 32);
    endfunction
    function automatic logic [15:0] size_of(int c, int b);
        return 16'(64 + c * 8 + b);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [phase %s] %s: actual %0h expected %0h",
                     req, phase, what, act, exp);
        end
    endtask

    task automatic model_stop();
        m_run = 1'b0;
        m_ptr = 0;
        m_rem = 0;
        m_ovr = 1'b0;
        for (int c = 0; c < 4; c++) m_bpos[c] = 0;
    endtask

    task automatic model_enter(input int p, input bit busy, inout exp_t e);
        int c;
        m_ptr = p;
        m_rem = (m_tdur[p] == 0) ? 1 : int'(m_tdur[p]);
        if (!m_tidle[p]) begin
            c = int'(m_tch[p]);
            e.start = 1'b1;  e.ch = m_tch[p];
            e.src = src_of(c, m_bpos[c]);
            e.dst = dst_of(c, m_bpos[c]);
            e.size = size_of(c, m_bpos[c]);
            e.s_beg = 1'b1;  e.beg_ch = m_tch[p];
            if (busy) m_ovr = 1'b1;
            if (m_blast[c][m_bpos[c]] || m_bpos[c] == 3) m_bpos[c] = 0;
            else m_bpos[c] = m_bpos[c] + 1;
        end
    endtask

    task automatic do_tick(input bit busy);
        exp_t e;
        e = '{default: '0};
        @(negedge clk);
        tick = 1'b1;
        dma_busy = busy;
        if (!m_run) begin
            m_run = 1'b1;
            model_enter(0, busy, e);
        end else if (m_rem <= 1) begin
            if (!m_tidle[m_ptr]) begin
                e.s_end = 1'b1;
                e.end_ch = m_tch[m_ptr];
            end
            model_enter((m_tlast[m_ptr] || m_ptr == 15) ? 0 : m_ptr + 1, busy, e);
        end else begin
            m_rem = m_rem - 1;
        end
        e.ovr = m_ovr;
        exp_q.push_back(e);
        @(negedge clk);
        tick = 1'b0;
        dma_busy = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_row(input int a, input bit idle, input bit last,
                          input int c, input int d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(a); tbl_idle = idle; tbl_last = last;
        tbl_ch = 2'(c); tbl_dur = 8'(d);
        if (!en) begin
            m_tidle[a] = idle; m_tlast[a] = last; m_tch[a] = 2'(c); m_tdur[a] = 8'(d);
        end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic wr_buf(input int c, input int b, input bit last,
                          input logic [31:0] s);
        @(negedge clk);
        buf_we = 1'b1; buf_ch = 2'(c); buf_idx = 2'(b); buf_last = last;
        buf_src = s; buf_dst = dst_of(c, b); buf_size = size_of(c, b);
        if (!en) m_blast[c][b] = last;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        en = v;
        if (!v) model_stop();
        @(negedge clk);
    endtask

    // Scoreboard monitor: results are due one edge after the tick edge.
    always @(posedge clk) pend <= tick;

    always @(negedge clk) begin
        exp_t e;
        if (rst_n && !done) begin
            if (pend) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected result slot", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(dma_start == e.start, "R4", "dma_start", 64'(dma_start), 64'(e.start));
                    if (e.start && dma_start) begin
                        chk(dma_ch == e.ch, "R5", "dma_ch", 64'(dma_ch), 64'(e.ch));
                        chk(dma_src == e.src, "R5", "dma_src", 64'(dma_src), 64'(e.src));
                        chk(dma_dst == e.dst, "R5", "dma_dst", 64'(dma_dst), 64'(e.dst));
                        chk(dma_size == e.size, "R5", "dma_size", 64'(dma_size), 64'(e.size));
                    end
                    chk(slot_end == e.s_end, "R6", "slot_end", 64'(slot_end), 64'(e.s_end));
                    if (e.s_end)
                        chk(slot_end_ch == e.end_ch, "R6", "slot_end_ch",
                            64'(slot_end_ch), 64'(e.end_ch));
                    chk(slot_begin == e.s_beg, "R3", "slot_begin", 64'(slot_begin), 64'(e.s_beg));
                    if (e.s_beg)
                        chk(slot_begin_ch == e.beg_ch, "R6", "slot_begin_ch",
                            64'(slot_begin_ch), 64'(e.beg_ch));
                    chk(overrun == e.ovr, "R9", "overrun", 64'(overrun), 64'(e.ovr));
                end
            end else begin
                chk(!dma_start && !slot_end && !slot_begin, "R2", "pulse without tick",
                    {61'd0, dma_start, slot_end, slot_begin}, 0);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_tidle[i] = 1'b1; m_tlast[i] = 1'b1; m_tch[i] = '0; m_tdur[i] = 8'd1;
        end
        for (int c = 0; c < 4; c++) for (int b = 0; b < 4; b++) m_blast[c][b] = 1'b0;
        model_stop();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset.
        chk(!dma_start, "R1", "dma_start after reset", 64'(dma_start), 0);
        chk(!slot_begin && !slot_end, "R1", "slot reports after reset",
            {62'd0, slot_begin, slot_end}, 0);
        chk(!overrun, "R1", "overrun after reset", 64'(overrun), 0);

        // Reference schedule: A(ch0) 2, gap 1, B(ch1) 3, A 2, gap 4 -> 12 ticks.
        wr_row(0, 0, 0, 0, 2);
        wr_row(1, 1, 0, 0, 1);
        wr_row(2, 0, 0, 1, 3);
        wr_row(3, 0, 0, 0, 2);
        wr_row(4, 1, 1, 0, 4);
        // Channel A rotates over three buffers, channel B repeats one.
        wr_buf(0, 0, 0, src_of(0, 0));
        wr_buf(0, 1, 0, src_of(0, 1));
        wr_buf(0, 2, 1, src_of(0, 2));
        wr_buf(1, 0, 1, src_of(1, 0));

        // R3/R4/R5/R6: two full hyperperiods plus two ticks; tick 6 both ends B and begins A.
        phase = "R3";
        set_en(1'b1);
        for (int t = 0; t < 26; t++) do_tick(1'b0);

        // R10: busy on a tick entering a gap has no effect; R9: busy on a launch sets overrun.
        phase = "R10";
        do_tick(1'b1);
        phase = "R9";
        do_tick(1'b1);
        for (int t = 0; t < 4; t++) do_tick(1'b0);

        // R7: writes while running are ignored.
        phase = "R7";
        wr_row(0, 1, 1, 3, 5);
        wr_buf(0, 0, 1, 32'hDEAD_BEEF);
        do_tick(1'b0);

        // R8: stop clears overrun and rings; restart from row 0, buffer 0.
        phase = "R8";
        set_en(1'b0);
        @(negedge clk);
        chk(!overrun, "R8", "overrun while stopped", 64'(overrun), 0);
        set_en(1'b1);
        for (int t = 0; t < 14; t++) do_tick(1'b0);

        // Second table: same channel twice in a row, each entry launches anew.
        phase = "R4";
        set_en(1'b0);
        wr_row(0, 0, 0, 1, 1);
        wr_row(1, 0, 0, 1, 1);
        wr_row(2, 1, 1, 0, 2);
        set_en(1'b1);
        for (int t = 0; t < 10; t++) do_tick(1'b0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "results outstanding", 64'(exp_q.size()), 0);
        finish_run();
    end

endmodule